// File: doc/BRIEF.md
# Virtual Interrupt Distributor Control Word Block

This block is the small global register window of a virtual interrupt distributor. It presents three 32-bit words on a simple valid/ready register port: a control word that holds the group-1 forwarding enable, a type word that describes the configured interrupt space, and an identification word. Address bits [3:2] choose the word. Every other address bit is ignored, and the fourth word position reads as zero.

The type and identification words are built from elaboration parameters: the count of shared interrupts, whether message-based (LPI) interrupts are supported, the ID widths, and the product, revision and implementer codes. When a write switches the enable from off to on, the block raises a single-cycle wake pulse toward every core, so that stalled cores look again for pending work.

A second write-only port serves state save and restore for debug or migration. A restore write to the control word acts like a normal control write. A restore write to any other word changes nothing. It only checks that the value equals what a read of that word returns now, and it flags an error one cycle later if the two differ.

Top module: `vdist_ctrl_regs`

## Requirements
- R1: The word is chosen by req_addr[3:2]: 0 selects control, 1 selects type, 2 selects identification, and 3 reads as 0x00000000. Address bits [1:0] do not affect the result.
- R2: A control read returns the enable in bit 1 and ones in bit 4 (affinity routing) and bit 6 (security disabled). All other bits are zero, so the value is 0x50 or 0x52.
- R3: An accepted bus write to the control word stores only req_wdata[1] as the enable, and the new value is visible from the next cycle. Writes to the type, identification and reserved words have no effect on any read value.
- R4: wake_pulse is high for exactly the one cycle after a write that changes the enable from 0 to 1. It stays low for writes from 1 to 1, from 1 to 0 and from 0 to 0.
- R5: Type bits [4:0] hold (NUM_SPI + 32) / 32 - 1. With the defaults this value is 3.
- R6: Type bits [23:19] hold the ID width minus one. The width is LPI_ID_BITS when HAS_LPI is set and SPI_ID_BITS otherwise. Type bit 17 is set only when HAS_LPI is set. The default type word is 0x007A0003.
- R7: The identification word holds PRODUCT_ID in bits [31:24], REVISION in bits [15:12] and IMPL_CODE in bits [11:0]. The default value is 0x4B00243B.
- R8: A restore write to the control word sets the enable from rst_wdata[1] and raises the wake pulse under the same rule as a bus write.
- R9: A restore write to word 1, 2 or 3 changes no state. rst_err is high for one cycle after such a write if rst_wdata differs from the current read value of that word, and low otherwise.
- R10: If a bus write and a restore write both target the control word in the same cycle, the bus write decides the enable.
- R11: Reset clears the enable, and no wake pulse or error follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always accepts |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 4 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Read value of the word at req_addr |
| rst_valid | input | 1 | Restore write strobe |
| rst_addr | input | 4 | Restore byte address |
| rst_wdata | input | 32 | Restore write data |
| rst_err | output | 1 | Restore value mismatch, one cycle after the write |
| wake_pulse | output | 1 | One-cycle wake to all cores |

## Verification
On every cycle, the assertions check that the fixed control bits read as ones, that the reserved word reads as zero, and that a control write lands in the enable on the next cycle. They also check that a wake pulse occurs exactly when the enable rises, and that an error only follows a restore write to a non-control word. The bench's scenarios are needed for the rest. These are the exact type and identification values, writes to other words leaving reads unchanged, the restore compare both matching and mismatching, the priority between the two ports, and the cleared state after a mid-run reset.

// File: rtl/vdist_pkg.sv
package vdist_pkg;
   typedef enum logic [1:0] {
      WD_CTRL  = 2'd0,
      WD_TYPE  = 2'd1,
      WD_IDENT = 2'd2,
      WD_RSVD  = 2'd3
   } word_e;

   localparam int CTRL_EN_BIT    = 1;
   localparam int CTRL_ROUTE_BIT = 4;
   localparam int CTRL_NOSEC_BIT = 6;

   localparam int TYPE_LINES_LSB = 0;
   localparam int TYPE_LINES_W   = 5;
   localparam int TYPE_LPI_BIT   = 17;
   localparam int TYPE_IDW_LSB   = 19;
   localparam int TYPE_IDW_W     = 5;

   localparam int ID_PROD_LSB = 24;
   localparam int ID_REV_LSB  = 12;
   localparam int ID_IMPL_LSB = 0;

   localparam int PRIVATE_IRQS = 32;
endpackage

// File: rtl/vdist_word_sel.sv
module vdist_word_sel
   import vdist_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output word_e             word
);
   logic unused_addr_bits;
   assign unused_addr_bits = ^addr[1:0];
   assign word = word_e'(addr[3:2]);
endmodule

// File: rtl/vdist_enable_reg.sv
module vdist_enable_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_wr,
   input  logic bus_bit,
   input  logic rs_wr,
   input  logic rs_bit,
   output logic en,
   output logic wake
);
   logic en_next;

   always_comb begin
      en_next = en;
      if (bus_wr)
         en_next = bus_bit;
      else if (rs_wr)
         en_next = rs_bit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         wake <= 1'b0;
      end else begin
         en   <= en_next;
         wake <= !en && en_next;
      end
   end
endmodule

// File: rtl/vdist_read_build.sv
module vdist_read_build
   import vdist_pkg::*;
#(
   parameter int          NUM_SPI     = 96,
   parameter bit          HAS_LPI     = 1'b1,
   parameter int          LPI_ID_BITS = 16,
   parameter int          SPI_ID_BITS = 10,
   parameter logic [7:0]  PRODUCT_ID  = 8'h4B,
   parameter logic [3:0]  REVISION    = 4'd2,
   parameter logic [11:0] IMPL_CODE   = 12'h43B
) (
   input  word_e       word,
   input  logic        en,
   output logic [31:0] data
);
   localparam int LINES = (NUM_SPI + PRIVATE_IRQS) / 32 - 1;

   logic [31:0] ctrl_val;
   logic [31:0] type_val;
   logic [31:0] id_val;

   always_comb begin
      ctrl_val = '0;
      ctrl_val[CTRL_EN_BIT]    = en;
      ctrl_val[CTRL_ROUTE_BIT] = 1'b1;
      ctrl_val[CTRL_NOSEC_BIT] = 1'b1;
   end

   generate
      if (HAS_LPI) begin : g_lpi
         localparam int IDW = LPI_ID_BITS - 1;
         always_comb begin
            type_val = '0;
            type_val[TYPE_LINES_LSB +: TYPE_LINES_W] = TYPE_LINES_W'(LINES);
            type_val[TYPE_IDW_LSB +: TYPE_IDW_W]     = TYPE_IDW_W'(IDW);
            type_val[TYPE_LPI_BIT]                   = 1'b1;
         end
      end else begin : g_nolpi
         localparam int IDW = SPI_ID_BITS - 1;
         always_comb begin
            type_val = '0;
            type_val[TYPE_LINES_LSB +: TYPE_LINES_W] = TYPE_LINES_W'(LINES);
            type_val[TYPE_IDW_LSB +: TYPE_IDW_W]     = TYPE_IDW_W'(IDW);
         end
      end
   endgenerate

   always_comb begin
      id_val = '0;
      id_val[ID_PROD_LSB +: 8] = PRODUCT_ID;
      id_val[ID_REV_LSB +: 4]  = REVISION;
      id_val[ID_IMPL_LSB +: 12] = IMPL_CODE;
   end

   always_comb begin
      case (word)
         WD_CTRL:  data = ctrl_val;
         WD_TYPE:  data = type_val;
         WD_IDENT: data = id_val;
         default:  data = '0;
      endcase
   end
endmodule

// File: rtl/vdist_restore_cmp.sv
module vdist_restore_cmp
   import vdist_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        valid,
   input  word_e       word,
   input  logic [31:0] wdata,
   input  logic [31:0] cur,
   output logic        err
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         err <= 1'b0;
      else
         err <= valid && (word != WD_CTRL) && (wdata != cur);
   end
endmodule

// File: rtl/vdist_ctrl_regs.sv
module vdist_ctrl_regs
   import vdist_pkg::*;
#(
   parameter int          NUM_SPI     = 96,
   parameter bit          HAS_LPI     = 1'b1,
   parameter int          LPI_ID_BITS = 16,
   parameter int          SPI_ID_BITS = 10,
   parameter logic [7:0]  PRODUCT_ID  = 8'h4B,
   parameter logic [3:0]  REVISION    = 4'd2,
   parameter logic [11:0] IMPL_CODE   = 12'h43B
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic        req_write,
   input  logic [3:0]  req_addr,
   input  logic [31:0] req_wdata,
   output logic [31:0] rdata,
   input  logic        rst_valid,
   input  logic [3:0]  rst_addr,
   input  logic [31:0] rst_wdata,
   output logic        rst_err,
   output logic        wake_pulse
);
   localparam int ADDR_W    = 4;
   localparam int TOTAL_IRQ = NUM_SPI + PRIVATE_IRQS;

   generate
      if ((TOTAL_IRQ % 32) != 0 || TOTAL_IRQ > 1024 || NUM_SPI < 0) begin : g_bad_spi
         $error("NUM_SPI must make a multiple of 32 lines, at most 1024");
      end
      if (LPI_ID_BITS < 1 || LPI_ID_BITS > 32 || SPI_ID_BITS < 1 || SPI_ID_BITS > 32) begin : g_bad_idw
         $error("ID widths must lie in 1..32");
      end
   endgenerate

   word_e bus_word;
   word_e rs_word;
   logic  ctrl_en;
   logic  bus_ctrl_wr;
   logic  rs_ctrl_wr;
   logic [31:0] rs_cur;
   logic  unused_wdata;

   assign req_ready    = 1'b1;
   assign unused_wdata = ^{req_wdata[31:2], req_wdata[0]};

   vdist_word_sel #(.ADDR_W(ADDR_W)) u_bus_sel (.addr(req_addr), .word(bus_word));
   vdist_word_sel #(.ADDR_W(ADDR_W)) u_rs_sel  (.addr(rst_addr), .word(rs_word));

   assign bus_ctrl_wr = req_valid && req_write && (bus_word == WD_CTRL);
   assign rs_ctrl_wr  = rst_valid && (rs_word == WD_CTRL);

   vdist_enable_reg u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_wr  (bus_ctrl_wr),
      .bus_bit (req_wdata[CTRL_EN_BIT]),
      .rs_wr   (rs_ctrl_wr),
      .rs_bit  (rst_wdata[CTRL_EN_BIT]),
      .en      (ctrl_en),
      .wake    (wake_pulse)
   );

   vdist_read_build #(
      .NUM_SPI(NUM_SPI), .HAS_LPI(HAS_LPI), .LPI_ID_BITS(LPI_ID_BITS),
      .SPI_ID_BITS(SPI_ID_BITS), .PRODUCT_ID(PRODUCT_ID), .REVISION(REVISION),
      .IMPL_CODE(IMPL_CODE)
   ) u_bus_rd (.word(bus_word), .en(ctrl_en), .data(rdata));

   vdist_read_build #(
      .NUM_SPI(NUM_SPI), .HAS_LPI(HAS_LPI), .LPI_ID_BITS(LPI_ID_BITS),
      .SPI_ID_BITS(SPI_ID_BITS), .PRODUCT_ID(PRODUCT_ID), .REVISION(REVISION),
      .IMPL_CODE(IMPL_CODE)
   ) u_rs_rd (.word(rs_word), .en(ctrl_en), .data(rs_cur));

   vdist_restore_cmp u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (rst_valid),
      .word  (rs_word),
      .wdata (rst_wdata),
      .cur   (rs_cur),
      .err   (rst_err)
   );
endmodule

// File: rtl/vdist_ctrl_chk.sv
module vdist_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [3:0]  req_addr,
   input logic [31:0] req_wdata,
   input logic [31:0] rdata,
   input logic        rst_valid,
   input logic [3:0]  rst_addr,
   input logic        rst_err,
   input logic        wake_pulse,
   input logic        ctrl_en
);
   // R3
   bus_ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr[3:2] == 2'd0) |=> (ctrl_en == $past(req_wdata[1])));

   // R2
   ctrl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_addr[3:2] == 2'd0) |-> (rdata[4] && rdata[6] && rdata[1] == ctrl_en));

   // R1
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_addr[3:2] == 2'd3) |-> (rdata == 32'd0));

   // R4
   wake_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (ctrl_en && !$past(ctrl_en)));

   // R4
   rise_gives_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_en) |-> wake_pulse);

   // R9
   err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_err |-> $past(rst_valid && rst_addr[3:2] != 2'd0));
endmodule

bind vdist_ctrl_regs vdist_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .req_wdata  (req_wdata),
   .rdata      (rdata),
   .rst_valid  (rst_valid),
   .rst_addr   (rst_addr),
   .rst_err    (rst_err),
   .wake_pulse (wake_pulse),
   .ctrl_en    (ctrl_en)
);

// File: tb/vdist_ctrl_regs_test.sv
`timescale 1ns/1ps
module vdist_ctrl_regs_test;
   localparam int NSPI = 96;
   localparam int LPI_IDW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = 4'd0;
   logic [31:0] req_wdata = 32'd0;
   logic [31:0] rdata;
   logic        rst_valid = 1'b0;
   logic [3:0]  rst_addr = 4'd0;
   logic [31:0] rst_wdata = 32'd0;
   logic        rst_err;
   logic        wake_pulse;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   vdist_ctrl_regs uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rdata(rdata), .rst_valid(rst_valid), .rst_addr(rst_addr),
      .rst_wdata(rst_wdata), .rst_err(rst_err), .wake_pulse(wake_pulse)
   );

   // reference model state
   bit m_en = 0, m_wake = 0, m_err = 0;

   function automatic logic [31:0] exp_read(input int w, input bit en);
      case (w)
         0: return 32'h50 | (32'(en) << 1);
         1: return 32'((NSPI + 32) / 32 - 1) | (32'(LPI_IDW - 1) << 19) | (32'd1 << 17);
         2: return 32'h4B00243B;
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit bus_c, rs_c, nen;
      if (!rst_n) begin
         m_en = 0; m_wake = 0; m_err = 0;
      end else begin
         bus_c = req_valid && req_write && req_addr[3:2] == 2'd0;
         rs_c  = rst_valid && rst_addr[3:2] == 2'd0;
         nen = bus_c ? req_wdata[1] : (rs_c ? rst_wdata[1] : m_en);
         m_err = rst_valid && rst_addr[3:2] != 2'd0 &&
                 rst_wdata != exp_read(int'(rst_addr[3:2]), m_en);
         m_wake = !m_en && nen;
         m_en = nen;
      end
   end

   // per-cycle comparison, 5 ns before each rising edge
   always @(posedge clk) begin
      #15;
      if (rst_n && !finished) begin
         check("R1 rdata", rdata, exp_read(int'(req_addr[3:2]), m_en));
         check("R4 wake", 32'(wake_pulse), 32'(m_wake));
         check("R9 err", 32'(rst_err), 32'(m_err));
      end
   end

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_write = 0; req_wdata = 0;
   endtask

   task automatic rs_wr(input logic [3:0] a, input logic [31:0] d);
      rst_valid = 1; rst_addr = a; rst_wdata = d;
      @(negedge clk);
      rst_valid = 0; rst_wdata = 0;
   endtask

   task automatic rd(input logic [3:0] a, input string tag, input logic [31:0] exp);
      req_valid = 1; req_write = 0; req_addr = a;
      #2;
      check(tag, rdata, exp);
      @(negedge clk);
      req_valid = 0;
   endtask

   initial begin
      #400000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11 reset state
      check("R11 wake after reset", 32'(wake_pulse), 0);
      check("R11 err after reset", 32'(rst_err), 0);
      rd(4'h0, "R11 R2 ctrl after reset", 32'h50);
      // R5 R6 R7 R1
      rd(4'h4, "R5 R6 type word", 32'h007A0003);
      rd(4'h7, "R1 type with low bits set", 32'h007A0003);
      rd(4'h8, "R7 ident word", 32'h4B00243B);
      rd(4'hC, "R1 reserved word", 32'h0);
      // R4 rising enable gives one pulse
      bus_wr(4'h0, 32'h2);
      check("R4 wake on rise", 32'(wake_pulse), 1);
      @(negedge clk);
      check("R4 wake one cycle", 32'(wake_pulse), 0);
      // R3 only bit 1 kept; 1->1 gives no wake
      bus_wr(4'h1, 32'hFFFF_FFFF);
      check("R4 no wake on 1to1", 32'(wake_pulse), 0);
      rd(4'h0, "R3 R2 ctrl all-ones write", 32'h52);
      bus_wr(4'h0, 32'hFFFF_FFFD);
      check("R4 no wake on fall", 32'(wake_pulse), 0);
      rd(4'h0, "R3 enable cleared", 32'h50);
      // R3 writes to other words ignored
      bus_wr(4'h4, 32'h0);
      bus_wr(4'h8, 32'h1234_5678);
      bus_wr(4'hC, 32'hFFFF_FFFF);
      rd(4'h4, "R3 type unchanged", 32'h007A0003);
      rd(4'h8, "R3 ident unchanged", 32'h4B00243B);
      rd(4'hC, "R3 reserved still zero", 32'h0);
      // R8 restore write to control
      rs_wr(4'h0, 32'h2);
      check("R8 restore wake", 32'(wake_pulse), 1);
      rd(4'h0, "R8 restore enable", 32'h52);
      rs_wr(4'h0, 32'h0);
      rd(4'h0, "R8 restore clear", 32'h50);
      // R9 restore compare
      rs_wr(4'h4, 32'h007A0003);
      check("R9 match no err", 32'(rst_err), 0);
      rs_wr(4'h8, 32'h4B00243C);
      check("R9 mismatch err", 32'(rst_err), 1);
      @(negedge clk);
      check("R9 err one cycle", 32'(rst_err), 0);
      rs_wr(4'hC, 32'h1);
      check("R9 reserved mismatch", 32'(rst_err), 1);
      rs_wr(4'hE, 32'h0);
      check("R9 reserved match", 32'(rst_err), 0);
      rd(4'h8, "R9 ident unchanged", 32'h4B00243B);
      // R10 both ports write control
      req_valid = 1; req_write = 1; req_addr = 4'h0; req_wdata = 32'h0;
      rst_valid = 1; rst_addr = 4'h0; rst_wdata = 32'h2;
      @(negedge clk);
      req_valid = 0; req_write = 0; rst_valid = 0; rst_wdata = 0;
      check("R10 bus wins no wake", 32'(wake_pulse), 0);
      rd(4'h0, "R10 bus wins enable", 32'h50);
      // R11 reset mid run
      bus_wr(4'h0, 32'h2);
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
      check("R11 no wake after reset", 32'(wake_pulse), 0);
      rd(4'h0, "R11 enable cleared", 32'h50);
      repeat (3) @(negedge clk);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule